// File: doc/BRIEF.md
# Remote Mailbox Write Engine

This block turns one 64-bit command write into a single 32-bit store into the register space of a target core. The command says which core to reach and which word to write. It also carries the new data in its upper half and a four-bit byte-keep mask. The destination address comes from one of two decodes. The mailbox offset selects one of eight mailbox words above a fixed base. The direct offset takes a free 16-bit address from the command itself.

When any keep bit is set, the engine reads the destination word first and then writes back a merge of the two words. Kept bytes come from the old word and all other bytes come from the command. When the mask is empty, the engine skips the read and writes the command word whole. Every request on the register port carries the target core's index as the requester. The block reports the end of each accepted command with a one-cycle done pulse. That pulse carries an error flag when the core number is unknown.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After reset, busy, done, err and req_valid are all low.
- R2: A command on either command offset acts only when cmd_size is 8 (bytes). Any other size gives a done pulse with err low and no register request.
- R3: The target core number is cmd_data[25:16]. A value of NUM_CORES or more gives a done pulse with err high and no register request.
- R4: At the mailbox offset (MAIL_OFS), the destination address is MBOX_BASE + 0x20 + 4*cmd_data[4:2]. Bits 1:0 and 15:5 play no part.
- R5: At the direct offset (ANY_OFS), the destination address is cmd_data[15:0].
- R6: If any of cmd_data[30:27] is set, bit 27+i keeps byte i. The engine issues one read (req_write=0) to the destination. It then issues one write of (old & keep) | (cmd_data[63:32] & ~keep) to the same address.
- R7: If cmd_data[30:27] is zero, the engine issues no read. It issues one write of cmd_data[63:32].
- R8: Every register request carries req_core equal to the target core number.
- R9: A command at any other offset is dropped. done rises on the first cycle after acceptance, err is low, and no request is made.
- R10: busy is high from the cycle after acceptance up to and including the done cycle. A cmd_valid seen while busy is high is dropped.
- R11: done lasts exactly one cycle, and err is never high without done.
- R12: While req_valid is high and req_ready is low, req_valid, req_write, req_addr, req_wdata and req_core keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_offset | input | OFS_W | Offset of the write within the command window |
| cmd_size | input | 4 | Access size in bytes |
| cmd_data | input | 64 | Command word |
| cmd_busy | output | 1 | Engine occupied; new commands are dropped |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Decode error, valid with done |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register port accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 16 | Destination word address |
| req_wdata | output | 32 | Write data |
| req_core | output | CORE_W | Requester, the target core index |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | 32 | Read data |

## Verification
Two events can land on the same clock. A new command can arrive while the engine is still busy with a stalled read-modify-write, or it can arrive in the very cycle that done is high. The bench covers both cases. It holds req_ready low in a repeating pattern and strobes a second command in the middle of the sequence. It also strobes another command exactly on the done cycle. In both cases it passes only if the register model shows a single write and the dropped command's address is never touched.

// File: rtl/mbx_pkg.sv
// Shared types for the mailbox write engine.
// Assumes: the destination address space is 16 bits wide.
package mbx_pkg;
    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } mbx_state_e;

    typedef enum logic [1:0] {
        K_IGNORE,
        K_FAULT,
        K_DIRECT,
        K_RMW
    } mbx_kind_e;
endpackage

// File: rtl/mbx_decode.sv
// Decodes a command write into its kind, destination address, keep mask,
// target core and new data. Purely combinational.
// Assumes: NUM_CORES >= 2 and the core field is 10 bits wide.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int              OFS_W     = 12,
    parameter int              NUM_CORES = 4,
    parameter logic [OFS_W-1:0] MAIL_OFS = 12'h048,
    parameter logic [OFS_W-1:0] ANY_OFS  = 12'h158,
    parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1000,
    localparam int             CORE_W    = $clog2(NUM_CORES)
) (
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [3:0]        size_i,
    input  logic [63:0]       data_i,
    output mbx_kind_e         kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [3:0]        keep_o,
    output logic [CORE_W-1:0] core_o,
    output logic [31:0]       wdata_o
);
    localparam logic [ADDR_W-1:0] SLOT_BASE = MBOX_BASE + ADDR_W'(16'h20);

    logic [9:0] core_id;
    logic       is_mail;
    logic       is_any;
    logic       core_ok;
    logic       unused_bits;

    assign core_id     = data_i[25:16];
    assign is_mail     = (offset_i == MAIL_OFS);
    assign is_any      = (offset_i == ANY_OFS);
    assign core_ok     = (32'(core_id) < NUM_CORES);
    assign keep_o      = data_i[30:27];
    assign wdata_o     = data_i[63:32];
    assign core_o      = core_id[CORE_W-1:0];
    assign unused_bits = ^{data_i[31], data_i[26]};

    // Address selection between mailbox slot and free address.
    always_comb begin
        if (is_mail) addr_o = SLOT_BASE + {11'd0, data_i[4:2], 2'b00};
        else         addr_o = data_i[ADDR_W-1:0];
    end

    // Classification of the command.
    always_comb begin
        if (!(is_mail || is_any) || size_i != 4'd8) kind_o = K_IGNORE;
        else if (!core_ok)                          kind_o = K_FAULT;
        else if (keep_o != 4'd0)                    kind_o = K_RMW;
        else                                        kind_o = K_DIRECT;
    end
endmodule

// File: rtl/mbx_merge.sv
// Byte merge of an old word and a new word under a keep mask:
// a set keep bit takes that byte from the old word.
module mbx_merge #(
    parameter int BYTES = 4
) (
    input  logic [BYTES-1:0]   keep_i,
    input  logic [8*BYTES-1:0] old_i,
    input  logic [8*BYTES-1:0] new_i,
    output logic [8*BYTES-1:0] out_o
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign out_o[8*b +: 8] = keep_i[b] ? old_i[8*b +: 8] : new_i[8*b +: 8];
    end
endmodule

// File: rtl/mbx_fsm.sv
// Sequencer: idle, optional read and wait for data, write, done.
// Assumes: read data returns at some later cycle via rsp_valid.
module mbx_fsm
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  mbx_kind_e  kind_i,
    input  logic       req_ready,
    input  logic       rsp_valid,
    output mbx_state_e state_o,
    output logic       accept_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       req_valid_o,
    output logic       req_write_o
);
    mbx_state_e state_q, state_d;

    assign accept_o    = cmd_valid && (state_q == ST_IDLE);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign req_valid_o = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign req_write_o = (state_q == ST_WRITE);
    assign state_o     = state_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) begin
                unique case (kind_i)
                    K_RMW:    state_d = ST_READ;
                    K_DIRECT: state_d = ST_WRITE;
                    default:  state_d = ST_DONE;
                endcase
            end
            ST_READ:  if (req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_WRITE;
            ST_WRITE: if (req_ready) state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !req_valid_o); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready) |=> (req_valid_o && $stable(req_write_o))); // R12
endmodule

// File: rtl/mbox_cmd_engine.sv
// Remote mailbox write engine: one 64-bit command becomes one 32-bit store,
// with an optional read-merge, into a target core's register space.
// Assumes: the register port completes writes on req_ready and returns
// read data later on rsp_valid; NUM_CORES >= 2.
module mbox_cmd_engine
    import mbx_pkg::*;
#(
    parameter int               OFS_W     = 12,
    parameter int               NUM_CORES = 4,
    parameter logic [OFS_W-1:0] MAIL_OFS  = 12'h048,
    parameter logic [OFS_W-1:0] ANY_OFS   = 12'h158,
    parameter logic [15:0]      MBOX_BASE = 16'h1000,
    localparam int              CORE_W    = $clog2(NUM_CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OFS_W-1:0]  cmd_offset,
    input  logic [3:0]        cmd_size,
    input  logic [63:0]       cmd_data,
    output logic              cmd_busy,
    output logic              done,
    output logic              err,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [15:0]       req_addr,
    output logic [31:0]       req_wdata,
    output logic [CORE_W-1:0] req_core,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_rdata
);
    mbx_kind_e         dec_kind;
    logic [ADDR_W-1:0] dec_addr;
    logic [3:0]        dec_keep;
    logic [CORE_W-1:0] dec_core;
    logic [31:0]       dec_wdata;

    mbx_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        keep_q;
    logic [CORE_W-1:0] core_q;
    logic [31:0]       wdata_q;
    logic [31:0]       merged;

    mbx_state_e        state;
    logic              accept;

    mbx_decode #(
        .OFS_W(OFS_W), .NUM_CORES(NUM_CORES), .MAIL_OFS(MAIL_OFS),
        .ANY_OFS(ANY_OFS), .MBOX_BASE(MBOX_BASE)
    ) decode_i (
        .offset_i(cmd_offset), .size_i(cmd_size), .data_i(cmd_data),
        .kind_o(dec_kind), .addr_o(dec_addr), .keep_o(dec_keep),
        .core_o(dec_core), .wdata_o(dec_wdata)
    );

    mbx_merge #(.BYTES(4)) merge_i (
        .keep_i(keep_q), .old_i(rsp_rdata), .new_i(wdata_q), .out_o(merged)
    );

    mbx_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .kind_i(dec_kind),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .state_o(state),
        .accept_o(accept), .busy_o(cmd_busy), .done_o(done),
        .req_valid_o(req_valid), .req_write_o(req_write)
    );

    // Command capture on acceptance; merged data replaces the word on read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_IGNORE;
            addr_q  <= '0;
            keep_q  <= '0;
            core_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= dec_kind;
            addr_q  <= dec_addr;
            keep_q  <= dec_keep;
            core_q  <= dec_core;
            wdata_q <= dec_wdata;
        end else if (state == ST_WAIT && rsp_valid) begin
            wdata_q <= merged;
        end
    end

    assign req_addr  = addr_q;
    assign req_wdata = wdata_q;
    assign req_core  = core_q;
    assign err       = done && (kind_q == K_FAULT);

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R11
    AST_CORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (32'(req_core) < NUM_CORES)); // R8
    AST_REQ_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            ($stable(req_addr) && $stable(req_wdata) && $stable(req_core))); // R12
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && state == ST_WAIT) |=> (req_valid && req_write)); // R6
endmodule

// File: tb/mbox_cmd_engine_tb_top.sv
module mbox_cmd_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] MAIL = 12'h048;
    localparam logic [11:0] ANY  = 12'h158;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [11:0] cmd_offset = '0;
    logic [3:0]  cmd_size = '0;
    logic [63:0] cmd_data = '0;
    logic        cmd_busy, done, err, req_valid, req_write;
    logic        req_ready = 1'b1;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic [1:0]  req_core;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0, cyc = 0;
    bit stall = 1'b0, rsp_pending = 1'b0;
    logic [15:0] last_rd_addr, last_wr_addr;
    logic [1:0]  last_rd_core, last_wr_core;
    logic [31:0] pend_data;
    logic [31:0] mem [logic [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_offset(cmd_offset),
        .cmd_size(cmd_size), .cmd_data(cmd_data), .cmd_busy(cmd_busy), .done(done),
        .err(err), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] key(logic [1:0] c, logic [15:0] a);
        return {14'd0, c, a};
    endfunction

    function automatic logic [31:0] peek(logic [1:0] c, logic [15:0] a);
        if (mem.exists(key(c, a))) return mem[key(c, a)];
        return 32'hDEAD_0000 | {16'd0, a};
    endfunction

    // Register-port model: acts at negedge on the handshake of the next posedge.
    always @(negedge clk) begin
        cyc++;
        if (rsp_pending) begin
            rsp_valid = 1'b1; rsp_rdata = pend_data; rsp_pending = 1'b0;
        end else begin
            rsp_valid = 1'b0;
        end
        req_ready = stall ? (cyc % 3 == 0) : 1'b1;
        if (req_valid && req_ready && rst_n) begin
            if (req_write) begin
                mem[key(req_core, req_addr)] = req_wdata;
                wr_cnt++; last_wr_addr = req_addr; last_wr_core = req_core;
            end else begin
                rd_cnt++; last_rd_addr = req_addr; last_rd_core = req_core;
                pend_data = peek(req_core, req_addr); rsp_pending = 1'b1;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(logic [11:0] ofs, logic [3:0] sz, logic [63:0] d);
        cmd_offset = ofs; cmd_size = sz; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output int lat, output bit e);
        lat = 1;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        e = err;
    endtask

    function automatic logic [63:0] mk(logic [31:0] w, logic [3:0] keep,
                                       logic [9:0] core, logic [15:0] lo);
        return {w, 1'b0, keep, 1'b0, core, lo};
    endfunction

    task automatic t_reset();
        chk(!cmd_busy && !done && !err && !req_valid, "R1",
            {cmd_busy, done, err, req_valid}, 0);
    endtask

    task automatic t_mail_direct();
        int lat; bit e; int r0 = rd_cnt;
        issue(MAIL, 4'd8, mk(32'hCAFE_F00D, 4'd0, 10'd1, 16'hFFEF)); // slot 3
        wait_done(lat, e);
        chk(peek(2'd1, 16'h102C) == 32'hCAFE_F00D, "R4", peek(2'd1, 16'h102C), 32'hCAFE_F00D);
        chk(rd_cnt == r0 && lat == 2 && !e, "R7", {rd_cnt - r0, lat}, {32'd0, 32'd2});
        chk(last_wr_core == 2'd1, "R8", last_wr_core, 1);
        @(negedge clk);
        chk(!done && !cmd_busy, "R11", {done, cmd_busy}, 0);
    endtask

    task automatic t_any_rmw(logic [3:0] keep, logic [31:0] exp, bit stl);
        int lat; bit e; int r0 = rd_cnt, w0 = wr_cnt;
        mem[key(2'd2, 16'h0340)] = 32'h1122_3344;
        stall = stl;
        issue(ANY, 4'd8, mk(32'hAABB_CCDD, keep, 10'd2, 16'h0340));
        wait_done(lat, e);
        stall = 1'b0;
        chk(peek(2'd2, 16'h0340) == exp, "R6", peek(2'd2, 16'h0340), exp);
        chk(rd_cnt == r0 + 1 && wr_cnt == w0 + 1 && last_rd_addr == 16'h0340,
            "R6", {rd_cnt - r0, wr_cnt - w0}, {32'd1, 32'd1});
        chk(last_wr_addr == 16'h0340, "R5", last_wr_addr, 16'h0340);
        chk(last_rd_core == 2'd2 && last_wr_core == 2'd2, "R8",
            {last_rd_core, last_wr_core}, {2'd2, 2'd2});
        if (!stl) chk(lat == 4, "R6", lat, 4);
        @(negedge clk);
    endtask

    task automatic t_fault(logic [9:0] core);
        int lat; bit e; int r0 = rd_cnt, w0 = wr_cnt;
        issue(ANY, 4'd8, mk(32'h1, 4'd3, core, 16'h0500));
        wait_done(lat, e);
        chk(e && lat == 1, "R3", {e, lat}, {1'b1, 32'd1});
        @(negedge clk);
        chk(rd_cnt == r0 && wr_cnt == w0, "R3", {rd_cnt - r0, wr_cnt - w0}, 0);
    endtask

    task automatic t_ignored(logic [11:0] ofs, logic [3:0] sz, string req);
        int lat; bit e; int r0 = rd_cnt, w0 = wr_cnt;
        issue(ofs, sz, mk(32'h55, 4'd0, 10'd0, 16'h0600));
        wait_done(lat, e);
        chk(!e && lat == 1, req, {e, lat}, 1);
        @(negedge clk);
        chk(rd_cnt == r0 && wr_cnt == w0 && !done, req,
            {rd_cnt - r0, wr_cnt - w0}, 0);
    endtask

    task automatic t_busy_drop();
        int lat; bit e; int w0 = wr_cnt;
        stall = 1'b1;
        issue(ANY, 4'd8, mk(32'h0102_0304, 4'd1, 10'd3, 16'h0700));
        chk(cmd_busy, "R10", cmd_busy, 1);
        issue(ANY, 4'd8, mk(32'h9999_9999, 4'd0, 10'd3, 16'h0704));
        wait_done(lat, e);
        stall = 1'b0;
        issue(ANY, 4'd8, mk(32'h7777_7777, 4'd0, 10'd3, 16'h0708)); // lands on done cycle
        repeat (6) @(negedge clk);
        chk(wr_cnt == w0 + 1, "R10", wr_cnt - w0, 1);
        chk(!mem.exists(key(2'd3, 16'h0704)) && !mem.exists(key(2'd3, 16'h0708)),
            "R10", 0, 0);
        chk(peek(2'd3, 16'h0700) == 32'h0102_0300, "R6", peek(2'd3, 16'h0700), 32'h0102_0300);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mail_direct();
        t_any_rmw(4'b0101, 32'hAA22_CC44, 1'b0);
        t_any_rmw(4'b1111, 32'h1122_3344, 1'b0);
        t_any_rmw(4'b1110, 32'h1122_33DD, 1'b1);   // stalled port, R12
        t_fault(10'd4);
        t_fault(10'h3FF);
        t_ignored(MAIL, 4'd4, "R2");
        t_ignored(ANY, 4'd8 - 4'd7, "R2");
        t_ignored(12'h100, 4'd8, "R9");
        t_busy_drop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule